// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the master side of a two-wire management link to Ethernet PHYs. Software composes a whole clause-22 management frame as one 32-bit word and writes it to the command register. The block then clocks the frame out on the management clock. First come the preamble ones, then the 32 command bits, most significant first. For a read opcode the block lets go of the data line after the register address field. It samples the PHY's 16 data bits and returns them in the low half of the command register.

When a frame ends, a completion flag in the status register goes high. Software clears the flag by writing a one to it. The management clock rate comes from a divider register, which sets the half period in system clock cycles. The data line appears at the pins as three signals: an output value, an output enable and the sampled pad input. An external pull-up holds the line high when nobody drives it.

The control sequence runs through six named states.

- ST_IDLE moves to ST_PREAMBLE on an accepted command write.
- ST_PREAMBLE moves to ST_HEADER after the last preamble bit ends.
- ST_HEADER carries command bits 31:18 and moves to ST_TURN after 14 bits.
- ST_TURN moves to ST_DATA after 2 bits.
- ST_DATA moves to ST_DONE after 16 bits.
- ST_DONE lasts one cycle, raises completion and returns to ST_IDLE.

Every bit boundary is a falling edge of the management clock. Line changes happen at that edge. Read data is sampled in the cycle just before the rising edge.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: A register write to address 0 (command) while the block is idle starts a frame. No other write starts one.
- R2: Every frame begins with 32 bit times in which the block drives the line high.
- R3: Each half of the management clock lasts D system clock cycles. D is the value at address 2 (divider); a value of 0 acts as 1. The clock is low while the block is idle. The line changes only at a falling edge of the management clock.
- R4: If command bits 29:28 equal 10 (read), the block drives command bits 31:18 after the preamble. It then stops driving the line for both turnaround bit times and for all 16 data bit times.
- R5: On a read frame, the 16 bits sampled during the data phase replace command bits 15:0, most significant bit first. Bits 31:16 keep their written value.
- R6: At the end of a frame, bit 12 of the status register (address 1) becomes 1. Writing a 1 to bit 12 clears it. Writing a 0 to bit 12 leaves it unchanged.
- R7: For any other opcode (write), the block drives all 32 command bits after the preamble, with bits 15:0 as data. The command register reads back unchanged after the frame.
- R8: A command write that arrives while a frame is in progress is ignored. The register keeps its value and the running frame is unaltered.
- R9: A divider write while a frame is in progress is ignored.
- R10: After reset, the command register reads 0, status reads 0 and the divider reads 4. The clock is low and the line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 command, 1 status, 2 divider |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Sampled management data pad |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |

## Verification
The assertions assume three things about the inputs. Register writes are single-cycle strobes. The PHY drives the line only after the master has released it. The pad input is settled when the cycle before a rising clock edge samples it. The bench drives writes on falling system clock edges and lasts each one exactly one cycle. Its PHY responder changes the line only on falling management clock edges, and only from the second turnaround bit to the end of the data phase of read frames. It releases the line at the end of the frame. This means read data is stable a full half period before it is sampled, and the two drivers never overlap.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } mdio_state_e;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;

    localparam int DONE_BIT  = 12;
    localparam int CMD_W     = 32;
    localparam int DATA_W    = 16;
    localparam int HDR_BITS  = 14;
    localparam int TURN_BITS = 2;

    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clk_gen.sv
`timescale 1ns/1ps
module mdio_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_cnt;
    logic             tick;

    assign last_cnt  = (div == '0) ? '0 : div - DIV_W'(1);
    assign tick      = en && (cnt_q == last_cnt);
    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc); // R3
    AST_MDC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rise_tick && !fall_tick) |=> $stable(mdc)); // R3
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [CMD_W-1:0]  reg_wdata,
    output logic [CMD_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              done_pulse,
    input  logic [DATA_W-1:0] rx_data,
    output logic              start,
    output logic [DIV_W-1:0]  div
);
    logic [CMD_W-1:0] cmd_q;
    logic             done_q;
    logic [DIV_W-1:0] div_q;
    logic             wr_cmd;
    logic             wr_stat;
    logic             wr_div;

    assign wr_cmd  = reg_wr && (reg_addr == ADDR_CMD);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_div  = reg_wr && (reg_addr == ADDR_DIV);
    assign start   = wr_cmd && !busy;
    assign div     = div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (start) begin
            cmd_q <= reg_wdata;
        end else if (done_pulse && (cmd_q[29:28] == OP_READ)) begin
            cmd_q[DATA_W-1:0] <= rx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (done_pulse) begin
            done_q <= 1'b1;
        end else if (wr_stat && reg_wdata[DONE_BIT]) begin
            done_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_RESET);
        end else if (wr_div && !busy) begin
            div_q <= reg_wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CMD:  reg_rdata = cmd_q;
            ADDR_STAT: reg_rdata[DONE_BIT] = done_q;
            ADDR_DIV:  reg_rdata[DIV_W-1:0] = div_q;
            default:   reg_rdata = '0;
        endcase
    end

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> done_q); // R6
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[DONE_BIT] && !done_pulse) |=> !done_q); // R6
    AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && busy && !done_pulse) |=> $stable(cmd_q)); // R8
    AST_DIV_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(div_q)); // R9
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd_in,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              clk_en,
    output logic              done_pulse,
    output logic [DATA_W-1:0] rx_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int MAX_CNT = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
    localparam int CNT_W   = $clog2(MAX_CNT) + 1;
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    mdio_state_e       state_q, state_d;
    logic [CMD_W-1:0]  tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              rd_q;
    logic              last_bit;

    assign last_bit = fall_tick && (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)    state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (last_bit) state_d = ST_HEADER;
            ST_HEADER:   if (last_bit) state_d = ST_TURN;
            ST_TURN:     if (last_bit) state_d = ST_DATA;
            ST_DATA:     if (last_bit) state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // bit counter, shifter and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            rx_q  <= '0;
            cnt_q <= '0;
            rd_q  <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                tx_q  <= cmd_in;
                rd_q  <= (cmd_in[29:28] == OP_READ);
                cnt_q <= PRE_LAST;
            end
        end else begin
            if (fall_tick) begin
                if (cnt_q == '0) begin
                    unique case (state_q)
                        ST_PREAMBLE: cnt_q <= HDR_LAST;
                        ST_HEADER:   cnt_q <= TURN_LAST;
                        ST_TURN:     cnt_q <= DATA_LAST;
                        default:     cnt_q <= '0;
                    endcase
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                if (state_q inside {ST_HEADER, ST_TURN, ST_DATA}) begin
                    tx_q <= {tx_q[CMD_W-2:0], 1'b0};
                end
            end
            if (rise_tick && (state_q == ST_DATA) && rd_q) begin
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            end
        end
    end

    // outputs
    always_comb begin
        mdio_o     = 1'b0;
        mdio_oe    = 1'b0;
        clk_en     = 1'b0;
        done_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PREAMBLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
                clk_en  = 1'b1;
            end
            ST_HEADER: begin
                mdio_o  = tx_q[CMD_W-1];
                mdio_oe = 1'b1;
                clk_en  = 1'b1;
            end
            ST_TURN, ST_DATA: begin
                mdio_o  = rd_q ? 1'b0 : tx_q[CMD_W-1];
                mdio_oe = !rd_q;
                clk_en  = 1'b1;
            end
            ST_DONE: begin
                done_pulse = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign rx_data = rx_q;

    AST_PRE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREAMBLE) |-> (mdio_oe && mdio_o)); // R2
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEADER && last_bit && rd_q) |=> !mdio_oe); // R4
    AST_LINE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !fall_tick) |=> ($stable(mdio_o) && $stable(mdio_oe))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE)); // R1
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_PREAMBLE && mdio_oe)); // R1
endmodule

// File: rtl/mdio_frame_ctrl.sv
`timescale 1ns/1ps
module mdio_frame_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 4,
    parameter int PRE_LEN   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic              busy;
    logic              done_pulse;
    logic              start;
    logic              clk_en;
    logic              rise_tick;
    logic              fall_tick;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] rx_data;

    mdio_regs #(
        .DIV_W     (DIV_W),
        .DIV_RESET (DIV_RESET)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .done_pulse (done_pulse),
        .rx_data    (rx_data),
        .start      (start),
        .div        (div)
    );

    mdio_clk_gen #(
        .DIV_W (DIV_W)
    ) clkgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en),
        .div       (div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_fsm #(
        .PRE_LEN (PRE_LEN)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd_in     (reg_wdata),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_i     (mdio_i),
        .busy       (busy),
        .clk_en     (clk_en),
        .done_pulse (done_pulse),
        .rx_data    (rx_data),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );
endmodule

// File: tb/mdio_frame_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_frame_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_line;
    logic        phy_oe = 1'b0;
    logic        phy_o = 1'b0;
    logic        phy_read = 1'b0;
    logic [15:0] phy_word = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    mdio_frame_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_i    (mdio_line),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    // frame recorder and PHY responder
    int          cyc = 0;
    int          idx = 0;
    int          t_edge0 = 0;
    int          t_edge1 = 0;
    logic [63:0] seen = '0;
    logic [63:0] seen_oe = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge mdc) begin
        if (idx < 64) begin
            seen[63-idx]    = mdio_line;
            seen_oe[63-idx] = mdio_oe;
        end
        if (idx == 0) t_edge0 = cyc;
        if (idx == 1) t_edge1 = cyc;
        idx = idx + 1;
    end

    always @(negedge mdc) begin
        if (phy_read) begin
            if (idx == 47) begin
                phy_oe = 1'b1;
                phy_o  = 1'b0;
            end else if (idx >= 48 && idx < 64) begin
                phy_oe = 1'b1;
                phy_o  = phy_word[63-idx];
            end else if (idx >= 64) begin
                phy_oe = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic arm(input bit rd, input logic [15:0] w);
        idx      = 0;
        seen     = '0;
        seen_oe  = '0;
        phy_read = rd;
        phy_word = w;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        bit got = 0;
        for (int i = 0; i < 20000; i++) begin
            reg_read(2'd1, s);
            if (s[12]) begin
                got = 1;
                break;
            end
        end
        check(got, req, {63'd0, got}, 64'd1);
    endtask

    task automatic clear_done();
        reg_write(2'd1, 32'h0000_1000);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        reg_read(2'd0, v);
        check(v == 32'd0, "R10 cmd reset", {32'd0, v}, 64'd0);
        reg_read(2'd1, v);
        check(v == 32'd0, "R10 status reset", {32'd0, v}, 64'd0);
        reg_read(2'd2, v);
        check(v == 32'd4, "R10 divider reset", {32'd0, v}, 64'd4);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 pins idle", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic test_write_frame();
        logic [31:0] c;
        logic [31:0] v;
        c = {2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hA5C3};
        arm(1'b0, 16'h0);
        reg_write(2'd0, c);
        wait_done("R6 completion after write frame");
        check(seen[63:32] == 32'hFFFF_FFFF, "R2 preamble ones", {32'd0, seen[63:32]}, 64'hFFFF_FFFF);
        check(seen[31:0] == c, "R1 R7 write frame bits", {32'd0, seen[31:0]}, {32'd0, c});
        check(seen_oe == 64'hFFFF_FFFF_FFFF_FFFF, "R7 driven throughout", seen_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        check(t_edge1 - t_edge0 == 8, "R3 period at divider 4",
              64'(t_edge1 - t_edge0), 64'd8);
        reg_read(2'd0, v);
        check(v == c, "R7 cmd readback unchanged", {32'd0, v}, {32'd0, c});
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R3 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic test_clear();
        logic [31:0] v;
        reg_write(2'd1, 32'h0000_0000);
        reg_read(2'd1, v);
        check(v[12] == 1'b1, "R6 write zero keeps flag", {63'd0, v[12]}, 64'd1);
        clear_done();
        reg_read(2'd1, v);
        check(v[12] == 1'b0, "R6 write one clears flag", {63'd0, v[12]}, 64'd0);
    endtask

    task automatic test_read_frame(input logic [7:0] d, input logic [15:0] w);
        logic [31:0] c;
        logic [31:0] v;
        int per;
        per = (d == 0) ? 2 : 2 * int'(d);
        reg_write(2'd2, {24'd0, d});
        c = {2'b01, 2'b10, 5'h01, 5'h02, 2'b10, 16'hFFFF};
        arm(1'b1, w);
        reg_write(2'd0, c);
        wait_done("R6 completion after read frame");
        check(seen[31:18] == c[31:18], "R4 read header bits", {50'd0, seen[31:18]}, {50'd0, c[31:18]});
        check(seen_oe[17:0] == 18'd0, "R4 released turnaround and data", {46'd0, seen_oe[17:0]}, 64'd0);
        check(seen_oe[63:18] == {46{1'b1}}, "R4 driven before turnaround",
              {18'd0, seen_oe[63:18]}, {18'd0, {46{1'b1}}});
        check(t_edge1 - t_edge0 == per, "R3 period from divider",
              64'(t_edge1 - t_edge0), 64'(per));
        reg_read(2'd0, v);
        check(v == {c[31:16], w}, "R5 captured data", {32'd0, v}, {32'd0, c[31:16], w});
        clear_done();
    endtask

    task automatic test_busy_ignore();
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] v;
        reg_write(2'd2, 32'd3);
        a = {2'b01, 2'b01, 5'h05, 5'h11, 2'b10, 16'h1234};
        b = {2'b01, 2'b10, 5'h1F, 5'h1F, 2'b10, 16'hFFFF};
        arm(1'b0, 16'h0);
        reg_write(2'd0, a);
        repeat (40) @(negedge clk);
        reg_write(2'd0, b);
        reg_write(2'd2, 32'd9);
        reg_read(2'd0, v);
        check(v == a, "R8 cmd held while busy", {32'd0, v}, {32'd0, a});
        reg_read(2'd2, v);
        check(v == 32'd3, "R9 divider held while busy", {32'd0, v}, 64'd3);
        wait_done("R8 frame completes");
        check(seen[31:0] == a, "R8 frame unaltered", {32'd0, seen[31:0]}, {32'd0, a});
        check(t_edge1 - t_edge0 == 6, "R9 period unchanged", 64'(t_edge1 - t_edge0), 64'd6);
        clear_done();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_write_frame();
        test_clear();
        test_read_frame(8'd2, 16'h3C96);
        test_busy_ignore();
        test_read_frame(8'd0, 16'h8001);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule